// File: doc/BRIEF.md
# Prioritised Access Attribute Resolver

This block assigns a set of effective attributes to every memory reference, whether it is issued by the processor core or by the debug unit. The attributes are three flags: whether the reference may be cached, whether operand writes to it are handled precisely or imprecisely, and whether it is write-protected. The block is a pure lookup. Enforcing write protection and any cache behaviour belong to other blocks.

The resolver holds two programmable address regions and one default attribute set. Each region has an 8-bit base, an 8-bit mask, an enable and its own attributes. The resolver compares the top eight bits of the reference address against each region. Region 0 is tried first and region 1 second. If neither region hits, the default attribute set is used. The result is combinational, so it is valid in the same cycle as the address. A `hit_src` output reports which source supplied the attributes.

Software programs the configuration through a single-cycle write port. A write takes effect at the next rising clock edge.

Top module: `attr_resolver`

## Requirements
- R1: After synchronous active-low reset, both regions are disabled and the default attributes are noncacheable, precise and not write-protected, so every address gives `hit_src`=00 with all three flags 0.
- R2: An enabled region 0 whose masked base equals the masked address bits [31:24] supplies its own attributes, and `hit_src` is 01.
- R3: When region 0 and region 1 both hit, region 0's attributes are used and `hit_src` is 01.
- R4: When region 0 does not hit and an enabled region 1 does, region 1's attributes are used and `hit_src` is 10.
- R5: When neither region hits, the default attributes are used and `hit_src` is 00.
- R6: A mask bit of 1 makes the matching address bit a don't-care. The base bit at that position is also ignored.
- R7: A region whose enable bit is 0 never hits, whatever its base and mask hold.
- R8: The outputs depend combinationally on `ref_addr`. A new address gives new outputs within the same cycle, without a clock edge.
- R9: The write port loads the selected register at the rising clock edge when `wr_en` is 1. The selects are 0 for region 0, 1 for region 1 and 2 for the default set. Nothing changes before that edge. Nothing changes when `wr_en` is 0 or when `wr_sel` is 3.
- R10: For a region write, `wr_data` fields are:
  - [31:24] base
  - [23:16] mask
  - [15] enable
  - [2] write-protect
  - [1] imprecise
  - [0] cacheable

  A default write uses only bits [2:0], with the same meaning.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe for the configuration port |
| wr_sel | input | 2 | Target register: 0 region 0, 1 region 1, 2 default, 3 none |
| wr_data | input | 32 | Write data, with field layout as in R10 |
| ref_addr | input | 32 | Address of the memory reference being resolved |
| eff_cacheable | output | 1 | Effective cacheable flag |
| eff_imprecise | output | 1 | Effective imprecise-write flag |
| eff_wprot | output | 1 | Effective write-protect flag |
| hit_src | output | 2 | Source of the attributes: 00 default, 01 region 0, 10 region 1 |

## Verification
Every wrong piece of internal state shows up at the outputs in the same cycle that an address touching it is presented, because the path from configuration to outputs holds no register. Some configuration faults show up as a wrong `hit_src` together with flags from another source. These include a corrupted base, mask or enable, and a region loaded through the wrong select. A corrupted attribute field shows up only in the flags, and only while its own source is selected. For that reason, each test drives addresses that land in each region, in overlaps of the two regions and in gaps between them. A write applied one edge early or late shows up on the first address sampled between the write's setup and its clock edge.

// File: rtl/attr_resolver_pkg.sv
// Package: shared types for the access attribute resolver.
// Assumes a 32-bit write word and an 8-bit compared address tag.
package attr_resolver_pkg;

    localparam int AR_TAG_W  = 8;   // compared upper address bits
    localparam int AR_WORD_W = 32;  // configuration write word width

    // Field positions inside a configuration write word
    localparam int AR_BASE_HI = AR_WORD_W - 1;
    localparam int AR_MASK_HI = AR_BASE_HI - AR_TAG_W;
    localparam int AR_EN_BIT  = 15;

    // Effective attribute set; the bit order matches write bits [2:0]
    typedef struct packed {
        logic wprot;
        logic imprecise;
        logic cacheable;
    } acc_attr_t;

    // One programmable address region
    typedef struct packed {
        logic                en;
        logic [AR_TAG_W-1:0] base;
        logic [AR_TAG_W-1:0] mask;
        acc_attr_t           attr;
    } region_cfg_t;

endpackage

// File: rtl/region_reg.sv
// Module: region_reg
// Holds the configuration of one address region. It loads the decoded
// write fields when the write port selects this region's index.
// Assumes a synchronous active-low reset; after reset the region is
// disabled.
module region_reg
    import attr_resolver_pkg::*;
#(
    parameter int IDX   = 0,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  region_cfg_t      wr_cfg,
    output region_cfg_t      cfg_q
);

    logic sel_hit;

    // Decode whether this write targets this region
    always_comb begin
        sel_hit = wr_en && (wr_sel == SEL_W'(IDX));
    end

    // Configuration storage with reset to a disabled, cleared region
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (sel_hit) begin
            cfg_q <= wr_cfg;
        end
    end

endmodule

// File: rtl/default_reg.sv
// Module: default_reg
// Holds the fallback attribute set. This set is used when no region
// hits. Assumes a synchronous active-low reset; the reset value is
// noncacheable, precise and not write-protected.
module default_reg
    import attr_resolver_pkg::*;
#(
    parameter int IDX   = 2,
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  acc_attr_t        wr_attr,
    output acc_attr_t        attr_q
);

    // Default attribute storage, loaded when selected
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            attr_q <= '0;
        end else if (wr_en && (wr_sel == SEL_W'(IDX))) begin
            attr_q <= wr_attr;
        end
    end

endmodule

// File: rtl/region_match.sv
// Module: region_match
// Masked compare of an address tag against one region. A mask bit of 1
// excludes that tag bit from the compare. A disabled region never hits.
// Purely combinational.
module region_match
    import attr_resolver_pkg::*;
(
    input  logic [AR_TAG_W-1:0] addr_tag,
    input  region_cfg_t         cfg,
    output logic                hit
);

    logic [AR_TAG_W-1:0] diff;

    // Compare the tag with the base on unmasked bits, qualified by enable
    always_comb begin
        diff = (addr_tag ^ cfg.base) & ~cfg.mask;
        hit  = cfg.en && (diff == '0);
    end

endmodule

// File: rtl/attr_select.sv
// Module: attr_select
// Priority selection among region hits. The lowest-numbered hitting
// region wins. If no region hits, the default set is chosen. The source
// code is the region index plus one, or zero for the default.
module attr_select
    import attr_resolver_pkg::*;
#(
    parameter int NUM_REGIONS = 2,
    parameter int SRC_W       = 2
) (
    input  logic        [NUM_REGIONS-1:0] hits,
    input  region_cfg_t [NUM_REGIONS-1:0] cfgs,
    input  acc_attr_t                     dflt,
    output acc_attr_t                     attr,
    output logic        [SRC_W-1:0]       src
);

    // Scan from the lowest priority up so the highest priority overrides
    always_comb begin
        attr = dflt;
        src  = '0;
        for (int i = NUM_REGIONS - 1; i >= 0; i--) begin
            if (hits[i]) begin
                attr = cfgs[i].attr;
                src  = SRC_W'(i + 1);
            end
        end
    end

endmodule

// File: rtl/attr_resolver.sv
// Module: attr_resolver (top)
// Resolves the cacheable, imprecise-write and write-protect attributes
// of a reference address. It uses prioritised programmable regions and
// a default set. The configuration is written through a one-cycle write
// port. Assumes a synchronous active-low reset. The resolution path is
// combinational from ref_addr.
module attr_resolver
    import attr_resolver_pkg::*;
#(
    parameter  int ADDR_W      = 32,
    parameter  int NUM_REGIONS = 2,
    localparam int SEL_W       = $clog2(NUM_REGIONS + 2),
    localparam int SRC_W       = $clog2(NUM_REGIONS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_en,
    input  logic [SEL_W-1:0]     wr_sel,
    input  logic [AR_WORD_W-1:0] wr_data,
    input  logic [ADDR_W-1:0]    ref_addr,
    output logic                 eff_cacheable,
    output logic                 eff_imprecise,
    output logic                 eff_wprot,
    output logic [SRC_W-1:0]     hit_src
);

    localparam int LOW_W = ADDR_W - AR_TAG_W;

    region_cfg_t                   wr_cfg;
    acc_attr_t                     wr_attr;
    logic        [AR_TAG_W-1:0]    addr_tag;
    logic                          addr_low_unused;
    logic                          wr_spare_unused;
    region_cfg_t [NUM_REGIONS-1:0] cfg_q;
    logic        [NUM_REGIONS-1:0] hits;
    acc_attr_t                     dflt_q;
    acc_attr_t                     eff_attr;

    // Split the write word into its configuration fields
    always_comb begin
        wr_attr         = acc_attr_t'(wr_data[2:0]);
        wr_cfg.base     = wr_data[AR_BASE_HI -: AR_TAG_W];
        wr_cfg.mask     = wr_data[AR_MASK_HI -: AR_TAG_W];
        wr_cfg.en       = wr_data[AR_EN_BIT];
        wr_cfg.attr     = wr_attr;
        wr_spare_unused = ^wr_data[AR_EN_BIT-1:3];
    end

    // Take the compared tag from the top of the address
    always_comb begin
        addr_tag        = ref_addr[ADDR_W-1 -: AR_TAG_W];
        addr_low_unused = ^ref_addr[LOW_W-1:0];
    end

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_region
        region_reg #(
            .IDX   (g),
            .SEL_W (SEL_W)
        ) i_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_en),
            .wr_sel (wr_sel),
            .wr_cfg (wr_cfg),
            .cfg_q  (cfg_q[g])
        );

        region_match i_match (
            .addr_tag (addr_tag),
            .cfg      (cfg_q[g]),
            .hit      (hits[g])
        );
    end

    default_reg #(
        .IDX   (NUM_REGIONS),
        .SEL_W (SEL_W)
    ) i_dflt (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_attr (wr_attr),
        .attr_q  (dflt_q)
    );

    attr_select #(
        .NUM_REGIONS (NUM_REGIONS),
        .SRC_W       (SRC_W)
    ) i_sel (
        .hits (hits),
        .cfgs (cfg_q),
        .dflt (dflt_q),
        .attr (eff_attr),
        .src  (hit_src)
    );

    // Drive the flat attribute outputs
    always_comb begin
        eff_cacheable = eff_attr.cacheable;
        eff_imprecise = eff_attr.imprecise;
        eff_wprot     = eff_attr.wprot;
    end

endmodule

// File: rtl/attr_resolver_chk.sv
// Module: attr_resolver_chk
// Assertion checker bound into attr_resolver. It recomputes region hits
// from the stored configuration and relates them to the outputs. It
// also checks the timing of the write port. Written for two regions.
module attr_resolver_chk
    import attr_resolver_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            wr_sel,
    input  logic [AR_TAG_W-1:0]   wr_base_in,
    input  logic [2:0]            wr_attr_in,
    input  logic [AR_TAG_W-1:0]   addr_tag,
    input  region_cfg_t [1:0]     cfg_q,
    input  acc_attr_t             dflt_q,
    input  logic                  eff_cacheable,
    input  logic                  eff_imprecise,
    input  logic                  eff_wprot,
    input  logic [1:0]            hit_src
);

    logic      m0;
    logic      m1;
    acc_attr_t eff;

    // Independent recomputation of the hits and the flat output bundle
    always_comb begin
        m0  = cfg_q[0].en && (((addr_tag ^ cfg_q[0].base) & ~cfg_q[0].mask) == '0);
        m1  = cfg_q[1].en && (((addr_tag ^ cfg_q[1].base) & ~cfg_q[1].mask) == '0);
        eff = '{wprot: eff_wprot, imprecise: eff_imprecise, cacheable: eff_cacheable};
    end

    p_first_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
        m0 |-> hit_src == 2'b01);

    p_second_used_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!m0 && m1) |-> hit_src == 2'b10 && eff == cfg_q[1].attr);

    p_fallback_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!m0 && !m1) |-> hit_src == 2'b00 && eff == dflt_q);

    p_attr_copy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_src == 2'b01 |-> eff == cfg_q[0].attr);

    p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_q[0].en |-> hit_src != 2'b01);

    p_wr_load_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd0) |=> cfg_q[0].base == $past(wr_base_in));

    p_wr_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || wr_sel == 2'd3) |=> $stable(cfg_q) && $stable(dflt_q));

    p_default_load_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == 2'd2) |=> dflt_q == acc_attr_t'($past(wr_attr_in)));

endmodule

bind attr_resolver attr_resolver_chk i_attr_resolver_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .wr_sel        (wr_sel),
    .wr_base_in    (wr_data[31:24]),
    .wr_attr_in    (wr_data[2:0]),
    .addr_tag      (addr_tag),
    .cfg_q         (cfg_q),
    .dflt_q        (dflt_q),
    .eff_cacheable (eff_cacheable),
    .eff_imprecise (eff_imprecise),
    .eff_wprot     (eff_wprot),
    .hit_src       (hit_src)
);

// File: tb/test_attr_resolver.sv
// Directed bench for attr_resolver: one task per scenario.
module test_attr_resolver;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_sel = 2'd0;
    logic [31:0] wr_data = '0;
    logic [31:0] ref_addr = '0;
    logic        eff_cacheable;
    logic        eff_imprecise;
    logic        eff_wprot;
    logic [1:0]  hit_src;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    attr_resolver i_attr_resolver (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_sel        (wr_sel),
        .wr_data       (wr_data),
        .ref_addr      (ref_addr),
        .eff_cacheable (eff_cacheable),
        .eff_imprecise (eff_imprecise),
        .eff_wprot     (eff_wprot),
        .hit_src       (hit_src)
    );

    // Region word: base [31:24], mask [23:16], enable [15], attrs [2:0]
    function automatic logic [31:0] rword(input logic [7:0] base, input logic [7:0] mask,
                                          input logic en, input logic [2:0] attr);
        return {base, mask, en, 12'd0, attr};
    endfunction

    // Compare {src, wprot, imprecise, cacheable} with the expected value
    task automatic check(input string req, input logic [1:0] exp_src, input logic [2:0] exp_attr);
        logic [4:0] got;
        got = {hit_src, eff_wprot, eff_imprecise, eff_cacheable};
        total++;
        if (got !== {exp_src, exp_attr}) begin
            bad++;
            $display("FAIL %s addr=%h got=%b expected=%b", req, ref_addr, got, {exp_src, exp_attr});
        end
    endtask

    // Present an address mid-cycle and check the combinational result
    task automatic probe(input string req, input logic [31:0] a,
                         input logic [1:0] exp_src, input logic [2:0] exp_attr);
        @(negedge clk);
        ref_addr = a;
        #1;
        check(req, exp_src, exp_attr);
    endtask

    // One-cycle write through the configuration port
    task automatic cfg_write(input logic [1:0] sel, input logic [31:0] data);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_sel  = sel;
        wr_data = data;
        @(negedge clk);
        wr_en   = 1'b0;
        wr_data = '0;
    endtask

    task automatic t_reset;
        probe("R1", 32'h1234_5678, 2'b00, 3'b000);
        probe("R1", 32'hFFFF_FFFF, 2'b00, 3'b000);
    endtask

    task automatic t_default;
        cfg_write(2'd2, 32'hFFFF_FFFD);           // only [2:0]=101 matter
        probe("R10", 32'h0000_0000, 2'b00, 3'b101);
        probe("R5", 32'h7700_0000, 2'b00, 3'b101);
    endtask

    task automatic t_region0;
        cfg_write(2'd0, rword(8'h40, 8'h00, 1'b1, 3'b001));
        probe("R2", 32'h4000_1000, 2'b01, 3'b001);
        probe("R5", 32'h4100_0000, 2'b00, 3'b101);
    endtask

    task automatic t_region1;
        cfg_write(2'd1, rword(8'h80, 8'h0F, 1'b1, 3'b110));
        probe("R4", 32'h8A00_0000, 2'b10, 3'b110);
        probe("R5", 32'h9000_0000, 2'b00, 3'b101);
    endtask

    task automatic t_priority;
        cfg_write(2'd1, rword(8'h00, 8'hFF, 1'b1, 3'b010));   // region 1 covers all
        probe("R3", 32'h40AB_CDEF, 2'b01, 3'b001);
        probe("R4", 32'h5500_0000, 2'b10, 3'b010);
    endtask

    task automatic t_mask;
        cfg_write(2'd0, rword(8'h4F, 8'h0F, 1'b1, 3'b001));   // base low nibble masked
        probe("R6", 32'h4000_0000, 2'b01, 3'b001);
        probe("R6", 32'h4A00_0000, 2'b01, 3'b001);
        probe("R6", 32'h5F00_0000, 2'b10, 3'b010);
    endtask

    task automatic t_combinational;
        @(negedge clk);
        ref_addr = 32'h4300_0000;
        #1 check("R8", 2'b01, 3'b001);
        ref_addr = 32'hC300_0000;
        #1 check("R8", 2'b10, 3'b010);
    endtask

    task automatic t_ignored_writes;
        // wr_en low: a disabling word to region 0 must not land
        @(negedge clk);
        wr_sel  = 2'd0;
        wr_data = rword(8'h00, 8'h00, 1'b0, 3'b000);
        @(negedge clk);
        probe("R9", 32'h4000_0000, 2'b01, 3'b001);
        // select 3 writes nothing
        cfg_write(2'd3, rword(8'h00, 8'hFF, 1'b1, 3'b111));
        probe("R9", 32'h4000_0000, 2'b01, 3'b001);
        probe("R9", 32'h9900_0000, 2'b10, 3'b010);
        // a real write is invisible before its clock edge
        @(negedge clk);
        ref_addr = 32'h6000_0000;
        wr_en    = 1'b1;
        wr_sel   = 2'd0;
        wr_data  = rword(8'h60, 8'h00, 1'b1, 3'b100);
        #1 check("R9", 2'b10, 3'b010);
        @(posedge clk);
        #1 check("R9", 2'b01, 3'b100);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_disable;
        cfg_write(2'd0, rword(8'h60, 8'h00, 1'b0, 3'b100));
        probe("R7", 32'h6000_0000, 2'b10, 3'b010);
        cfg_write(2'd1, rword(8'h00, 8'hFF, 1'b0, 3'b010));
        probe("R7", 32'h6000_0000, 2'b00, 3'b101);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_default();
        t_region0();
        t_region1();
        t_priority();
        t_mask();
        t_combinational();
        t_ignored_writes();
        t_disable();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run is counted as a failed check
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired got=running expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule